// File: doc/BRIEF.md
# Phase-Coincidence Gated Frequency Counter

This block measures an unknown signal against a reference clock by counting both over one interval whose two ends both fall on phase-coincidence points. Both inputs are brought into a fast system clock through two-flop synchronizers, and their rising edges are detected there. A coincidence pulse is raised in any system-clock cycle where a rising edge of one signal meets a rising edge of the other within a programmable window. The host drives a coarse preset gate that sets the nominal measurement time. The counting gate follows that level only when a coincidence pulse occurs. It therefore opens at the first coincidence after the preset gate rises and closes at the first coincidence after the preset gate falls.

While the synchronized gate is open, two counters accumulate rising edges of the reference and of the measured signal. Both counts cover the same whole number of common periods, so the ratio fX = f0 · NX / N0 computed by the host has no ±1 count error. When the gate closes, a done flag rises. The host then reads each wide count one byte at a time through a small register read port. Reading the status register clears the done flag.

Top module: `freq_coinc_counter`

## Requirements
- R1: After reset, `gate_open`, `done` and `coinc` are 0 and every readable register returns 0.
- R2: Each input is synchronized by two flops and a rising edge is the synchronized value going from 0 to 1. When both detected edges fall in the same cycle and `win_cfg` is 0, `coinc` is high for exactly one cycle per common period.
- R3: A rising edge of one signal that follows a rising edge of the other by k cycles (k ≥ 1) gives a coincidence pulse if k ≤ `win_cfg`, and gives none if k > `win_cfg`.
- R4: A rising `preset_gate` does not open the gate by itself. `gate_open` rises only in the cycle after the first coincidence pulse seen while `preset_gate` is high.
- R5: After `preset_gate` falls, `gate_open` stays high until the first coincidence pulse and falls in the cycle after it. The gate therefore spans a whole number m of common periods.
- R6: While `gate_open` is high, the reference counter adds one per detected reference edge and the measured counter adds one per detected measured edge. Over m common periods of length L, the counts are m·L/P0 and m·L/PX, where P0 and PX are the input periods.
- R7: Both counters clear to 0 on a rising `preset_gate`, so a new measurement never accumulates onto the old one.
- R8: `done` rises in the same cycle `gate_open` falls. It stays high until a read of the status register, which clears it.
- R9: A read with `rd_en` returns its data on `rd_data` one cycle later. Addresses 0–3 give the reference count bytes, least significant first. Addresses 4–7 give the measured count bytes. Address 8 is status, with bit 0 = done and bit 1 = gate open. Other addresses read 0.
- R10: Inputs of nearly equal frequency (periods of 10 and 11 cycles) are measured with the exact whole-period counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference signal, asynchronous |
| meas_in | input | 1 | Signal under measurement, asynchronous |
| preset_gate | input | 1 | Host nominal measurement gate, synchronous to clk |
| win_cfg | input | WIN_W | Coincidence window in cycles (0 = same cycle only) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Registered read data |
| gate_open | output | 1 | Synchronized counting gate |
| done | output | 1 | Measurement complete flag |
| coinc | output | 1 | Coincidence pulse |

## Verification
A rising input edge reaches `coinc` after two synchronizer flops, so a pulse appears two or three cycles after the bench drives the edge. The bench counts pulses only in a span that starts five cycles after a common-period boundary and is a whole number of periods long, so synchronizer lag cannot move a pulse across the edge of the span. The preset gate is always changed half a common period away from any coincidence, and the gate state is sampled half a period after the expected coincidence. That leaves many cycles of margin for the one-cycle step from pulse to gate. Read data is sampled on the falling edge after the rising edge that registers it, and `done` is sampled a full period after the closing coincidence.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  // Width of one readable register slice.
  localparam int BYTE_W = 8;

  // A partner edge seen `age` cycles ago (age 0 = previous cycle) counts
  // as coincident if it lies within the window of `win` cycles.
  function automatic logic age_in_window(int unsigned age, int unsigned win);
    return (age < win);
  endfunction

  // Select byte `idx` of a count (counts of up to 64 bits).
  function automatic logic [BYTE_W-1:0] pick_byte(logic [63:0] v, int idx);
    return v[idx*BYTE_W +: BYTE_W];
  endfunction

  // Count of whole-period edges expected for a gate of m common periods.
  function automatic int unsigned edges_in_gate(int unsigned m, int unsigned l,
                                                int unsigned p);
    return (m * l) / p;
  endfunction

endpackage

// File: rtl/fcc_edge_sync.sv
module fcc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // A detected rising edge needs a low sample after it before the next one
  AST_RISE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2

endmodule

// File: rtl/fcc_coinc_det.sv
module fcc_coinc_det #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ref,
  input  logic             rise_meas,
  input  logic [WIN_W-1:0] win,
  output logic             coinc
);
  import fcc_pkg::*;

  localparam logic [WIN_W-1:0] AGE_MAX = '1;

  logic [1:0]             rise_v;
  logic [1:0]             recent;
  logic [1:0][WIN_W-1:0]  age_q;

  assign rise_v = {rise_meas, rise_ref};

  // Per channel: cycles since that channel's last rising edge, saturating.
  for (genvar g = 0; g < 2; g++) begin : g_age
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age_q[g] <= AGE_MAX;
      else if (rise_v[g])  age_q[g] <= '0;
      else if (age_q[g] != AGE_MAX) age_q[g] <= age_q[g] + 1'b1;
    end
    assign recent[g] = age_in_window(int'(age_q[g]), int'(win));
  end

  // Same-cycle edges, or an edge whose partner came within the window.
  assign coinc = (rise_v[0] & (rise_v[1] | recent[1])) |
                 (rise_v[1] & recent[0]);

endmodule

// File: rtl/fcc_gate_sync.sv
module fcc_gate_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic coinc,
  input  logic preset,
  output logic gate,
  output logic preset_rise,
  output logic close_evt
);
  logic gate_q;
  logic preset_q;

  // D flip-flop on the preset level, enabled only by a coincidence pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q   <= 1'b0;
      preset_q <= 1'b0;
    end else begin
      preset_q <= preset;
      if (coinc) gate_q <= preset;
    end
  end

  assign gate        = gate_q;
  assign preset_rise = preset & ~preset_q;
  assign close_evt   = coinc & gate_q & ~preset;

  AST_GATE_MOVES_AT_COINC: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q != $past(gate_q)) |-> $past(coinc)); // R4
  AST_GATE_OPENS_WITH_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(preset)); // R5

endmodule

// File: rtl/fcc_counters.sv
module fcc_counters #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             gate,
  input  logic [1:0]       rise,
  output logic [CNT_W-1:0] cnt_ref,
  output logic [CNT_W-1:0] cnt_meas
);
  logic [1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q[g] <= '0;
      else if (clr)                cnt_q[g] <= '0;
      else if (gate && rise[g])    cnt_q[g] <= cnt_q[g] + 1'b1;
    end

    AST_COUNT_ONLY_IN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q[g] != $past(cnt_q[g])) && !$past(clr)) |-> $past(gate)); // R6
  end

  assign cnt_ref  = cnt_q[0];
  assign cnt_meas = cnt_q[1];

endmodule

// File: rtl/fcc_readout.sv
module fcc_readout #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_done,
  input  logic              clr_done,
  input  logic              gate,
  input  logic [CNT_W-1:0]  cnt_ref,
  input  logic [CNT_W-1:0]  cnt_meas,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              done
);
  import fcc_pkg::*;

  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int STAT_A = 2 * NBYTES;

  logic       done_q;
  logic       stat_rd;
  logic [7:0] rd_next;
  logic [7:0] rd_q;
  int         a;

  assign a       = int'(rd_addr);
  assign stat_rd = rd_en && (a == STAT_A);

  always_comb begin
    rd_next = '0;
    if (a < NBYTES)          rd_next = pick_byte(64'(cnt_ref), a);
    else if (a < STAT_A)     rd_next = pick_byte(64'(cnt_meas), a - NBYTES);
    else if (a == STAT_A)    rd_next = {6'b0, gate, done_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (set_done)                 done_q <= 1'b1;
      else if (stat_rd || clr_done) done_q <= 1'b0;
      if (rd_en) rd_q <= rd_next;
    end
  end

  assign rd_data = rd_q;
  assign done    = done_q;

  AST_DONE_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !set_done) |=> !done_q); // R8

endmodule

// File: rtl/freq_coinc_counter.sv
module freq_coinc_counter #(
  parameter int CNT_W  = 32,
  parameter int WIN_W  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              meas_in,
  input  logic              preset_gate,
  input  logic [WIN_W-1:0]  win_cfg,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              gate_open,
  output logic              done,
  output logic              coinc
);
  logic [1:0]       sig_v;
  logic [1:0]       rise_v;
  logic             coinc_w;
  logic             gate_w;
  logic             preset_rise;
  logic             close_evt;
  logic [CNT_W-1:0] cnt_ref;
  logic [CNT_W-1:0] cnt_meas;

  assign sig_v = {meas_in, ref_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    fcc_edge_sync #(.STAGES(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sig_v[g]),
      .rise (rise_v[g])
    );
  end

  fcc_coinc_det #(.WIN_W(WIN_W)) u_coinc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_ref (rise_v[0]),
    .rise_meas(rise_v[1]),
    .win      (win_cfg),
    .coinc    (coinc_w)
  );

  fcc_gate_sync u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .coinc      (coinc_w),
    .preset     (preset_gate),
    .gate       (gate_w),
    .preset_rise(preset_rise),
    .close_evt  (close_evt)
  );

  fcc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (preset_rise),
    .gate    (gate_w),
    .rise    (rise_v),
    .cnt_ref (cnt_ref),
    .cnt_meas(cnt_meas)
  );

  fcc_readout #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_done(close_evt),
    .clr_done(preset_rise),
    .gate    (gate_w),
    .cnt_ref (cnt_ref),
    .cnt_meas(cnt_meas),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .done    (done)
  );

  assign gate_open = gate_w;
  assign coinc     = coinc_w;

  AST_DONE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_w) |-> done); // R8

endmodule

// File: tb/tb_freq_coinc_counter.sv
module tb_freq_coinc_counter;
  localparam int BASE = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       meas_in = 1'b0;
  logic       preset_gate = 1'b0;
  logic [3:0] win_cfg = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       gate_open;
  logic       done;
  logic       coinc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wd = 0;
  bit run = 1'b0;
  int p0 = 10, px = 10, off = 0;
  int mon_lo = 0, mon_hi = 0, n_coinc = 0;

  freq_coinc_counter dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .meas_in(meas_in),
    .preset_gate(preset_gate), .win_cfg(win_cfg), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_open(gate_open),
    .done(done), .coinc(coinc)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!run) cyc <= 0;
    else      cyc <= cyc + 1;
  end

  // Waveform generator and coincidence monitor, both on the falling edge
  always @(negedge clk) begin
    if (mon_lo <= cyc && cyc < mon_hi && run && coinc) n_coinc = n_coinc + 1;
    ref_in  = run && cyc >= BASE && (((cyc - BASE) % p0) < p0 / 2);
    meas_in = run && cyc >= BASE + off && (((cyc - BASE - off) % px) < px / 2);
  end

  always @(posedge clk) begin
    wd = wd + 1;
    if (wd > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gcd(int a, int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int lcm(int a, int b);
    return (a / gcd(a, b)) * b;
  endfunction

  task automatic wait_cyc(int n);
    do @(negedge clk); while (cyc < n);
  endtask

  task automatic read_byte(int addr, output int val);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = 4'(addr);
    @(negedge clk);
    val = int'(rd_data);
    rd_en = 1'b0;
  endtask

  task automatic read_count(int base_addr, output int val);
    int b;
    val = 0;
    for (int i = 0; i < 4; i++) begin
      read_byte(base_addr + i, b);
      val = val | (b << (8 * i));
    end
  endtask

  task automatic start_wave(int rp, int mp, int o, int w);
    run = 1'b0;
    repeat (6) @(negedge clk);
    p0 = rp; px = mp; off = o; win_cfg = 4'(w);
    n_coinc = 0;
    @(negedge clk);
    run = 1'b1;
  endtask

  // R1
  task automatic t_reset();
    int v;
    chk("R1 gate_open", int'(gate_open), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 coinc", int'(coinc), 0);
    read_count(0, v);  chk("R1 ref count", v, 0);
    read_count(4, v);  chk("R9 meas count after reset", v, 0);
    read_byte(8, v);   chk("R1 status", v, 0);
    read_byte(13, v);  chk("R9 unused address", v, 0);
  endtask

  // R2 / R3: count coincidence pulses over k whole common periods
  task automatic t_pulses(string req, int rp, int mp, int o, int w, int k, int exp);
    int l;
    l = lcm(rp, mp);
    start_wave(rp, mp, o, w);
    mon_lo = BASE + 5;
    mon_hi = BASE + 5 + k * l;
    wait_cyc(mon_hi + 2);
    chk(req, n_coinc, exp);
  endtask

  // R4..R10: full measurement with the preset gate set half a period off
  task automatic t_measure(string req, int rp, int mp, int o, int w, int ja, int jb);
    int l, a, b, v, m;
    l = lcm(rp, mp);
    m = jb - ja;
    a = BASE + ja * l + l / 2;
    b = BASE + jb * l + l / 2;
    start_wave(rp, mp, o, w);
    wait_cyc(a);
    preset_gate = 1'b1;
    wait_cyc(a + 4);
    chk({req, " R4 gate shut before coincidence"}, int'(gate_open), 0);
    read_byte(0, v);
    chk({req, " R7 count cleared on preset rise"}, v, 0);
    wait_cyc(BASE + (ja + 1) * l + l / 2);
    chk({req, " R4 gate open after coincidence"}, int'(gate_open), 1);
    wait_cyc(b);
    preset_gate = 1'b0;
    wait_cyc(b + 3);
    chk({req, " R5 gate held past preset fall"}, int'(gate_open), 1);
    wait_cyc(BASE + (jb + 1) * l + l / 2);
    chk({req, " R5 gate closed"}, int'(gate_open), 0);
    chk({req, " R8 done set"}, int'(done), 1);
    read_count(0, v);
    chk({req, " R6 ref count"}, v, (m * l) / rp);
    read_count(4, v);
    chk({req, " R6 meas count"}, v, (m * l) / mp);
    read_byte(8, v);
    chk({req, " R8 status before clear"}, v, 1);
    read_byte(8, v);
    chk({req, " R8 status after clear"}, v, 0);
    chk({req, " R8 done port cleared"}, int'(done), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulses("R2 aligned pulses", 10, 9, 0, 0, 4, 4);
    t_pulses("R3 lag 2 window 1", 10, 20, 2, 1, 5, 0);
    t_pulses("R3 lag 2 window 2", 10, 20, 2, 2, 5, 5);
    t_pulses("R3 lag 1 window 0", 10, 20, 1, 0, 5, 0);
    t_measure("R6 10vs9", 10, 9, 0, 0, 1, 5);
    t_measure("R10 10vs11", 10, 11, 0, 0, 0, 3);
    t_measure("R3 windowed", 10, 20, 1, 1, 1, 6);
    t_measure("R7 rerun", 10, 9, 0, 0, 2, 4);
    run = 1'b0;
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule